// File: doc/BRIEF.md
# Three-Wire Daisy-Chain Bus Arbiter

This block decides which of several modules sharing a bus becomes bus master. A central grant controller and a chain of per-module arbitration cells share three lines. REQUEST is the wired-OR of every module that wants the bus and does not yet own it. BUSY is the wired-OR of the current owner. GRANT leaves the controller, enters the cell at index 0, and travels from cell to cell. A cell that is not requesting passes GRANT on to the next cell. A cell that is requesting, or that owns the bus, blocks it. Position in the chain sets priority, so index 0 is the highest.

Module request inputs are asynchronous, so each cell resynchronizes its request through a chain of flip-flops before using it. A cell takes the bus only when three conditions hold in the same cycle: its incoming GRANT has just risen, BUSY is low, and it has a pending request. A request that appears while GRANT is already high cannot take the bus by looking at GRANT alone. It waits for the next rising edge.

A module keeps the bus for as long as it holds its request input high. It releases the bus by dropping that input.

Top module: `daisy_arbiter`

## Requirements
- R1: After synchronous reset, all of these are low: `own_o`, `grant_o`, `busy_o` and `request_o`.
- R2: A level on `req_i[k]` reaches the cell after `SYNC_STAGES` clock edges. `request_o` is high exactly when at least one module has a synchronized request and does not own the bus.
- R3: `grant_o` rises only after a cycle in which `request_o` was high and `busy_o` was low. In the cycle after any cycle with `busy_o` high, `grant_o` is low. It stays low until BUSY has been released.
- R4: A cell takes the bus only at a rising edge of its incoming grant, with BUSY low and its synchronized request pending. A request that appears while grant is already high waits for a new grant edge.
- R5: A cell with no synchronized request and no ownership passes grant to the next cell. A requesting or owning cell blocks grant. When grant reaches the end of the chain, BUSY and REQUEST are both low.
- R6: When several requests are pending at a grant edge, the cell with the lowest index takes the bus.
- R7: `own_o` is one-hot or zero in every cycle.
- R8: `own_o[k]` and `busy_o` go high on the clock after the capture. They stay high while the owner's synchronized request stays high, and fall on the clock after it is seen low.
- R9: An owning module no longer contributes to `request_o`.
- R10: `grant_o` lasts exactly two cycles. If nobody captures the bus, grant returns low and is raised again while requests remain, so a late request is served on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MOD | Asynchronous bus request per module; index 0 has the highest priority |
| own_o | output | N_MOD | Bus ownership per module |
| grant_o | output | 1 | GRANT driven by the controller into cell 0 |
| busy_o | output | 1 | Wired-OR BUSY line |
| request_o | output | 1 | Wired-OR REQUEST line |

## Verification
Several properties are checked on every cycle: single ownership, the conditions for a grant to rise, the drop of grant after BUSY, capture only on a grant edge with BUSY idle, the retention of ownership, and the quiet lines when grant reaches the end of the chain. Other behaviour only shows up in scenarios: priority between simultaneous requests, hand-over after a release, a request that arrives too late for the current edge, and a request pulse too short to be served. The bench covers these with a behavioural cycle model that it compares against the design on every clock, plus directed cases.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Controller phases: grant is high in RAISE and HOLD only
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_RAISE = 2'd1,
        GS_HOLD  = 2'd2,
        GS_WAIT  = 2'd3
    } gnt_state_e;

    // What one arbitration cell contributes to the shared lines
    typedef struct packed {
        logic pend;   // contribution to wired-OR REQUEST
        logic own;    // contribution to wired-OR BUSY
        logic gout;   // grant passed to the next cell
    } cell_out_t;

    function automatic logic is_granting(input gnt_state_e s);
        return (s == GS_RAISE) || (s == GS_HOLD);
    endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_multi
            logic [STAGES-1:0] shift_q;
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= {shift_q[STAGES-2:0], d};
            end
            assign q = shift_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/arb_grant.sv
module arb_grant
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_line,
    input  logic busy_line,
    output logic grant
);
    gnt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE:  if (req_line && !busy_line) state_d = GS_RAISE;
            GS_RAISE: state_d = GS_HOLD;
            GS_HOLD:  state_d = busy_line ? GS_WAIT : GS_IDLE;
            GS_WAIT:  if (!busy_line) state_d = GS_IDLE;
            default:  state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GS_IDLE;
        else     state_q <= state_d;
    end

    assign grant = is_granting(state_q);

    // R3: grant rises only after REQUEST high with BUSY idle
    p_grant_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> ($past(req_line) && !$past(busy_line)));

    // R3: grant is low in the cycle after BUSY is seen
    p_grant_drop_r3: assert property (@(posedge clk) disable iff (rst)
        busy_line |=> !grant);
endmodule

// File: rtl/arb_cell.sv
module arb_cell
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_async,
    input  logic      gin,
    input  logic      busy_line,
    output cell_out_t co
);
    logic req_s;
    logic gin_q;
    logic own_q;
    logic take;

    arb_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_async),
        .q   (req_s)
    );

    // capture: rising grant edge, idle bus, local pending request
    assign take = req_s && !own_q && gin && !gin_q && !busy_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            gin_q <= 1'b0;
            own_q <= 1'b0;
        end else begin
            gin_q <= gin;
            own_q <= take || (own_q && req_s);
        end
    end

    always_comb begin
        co.pend = req_s && !own_q;
        co.own  = own_q;
        co.gout = gin && !req_s && !own_q;
    end

    // R4: ownership starts only after a grant edge seen with BUSY idle
    p_take_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(own_q) |-> ($past(gin) && !$past(gin_q) && !$past(busy_line)));

    // R8: owner keeps the bus while its request is held
    p_keep_owner_r8: assert property (@(posedge clk) disable iff (rst)
        (own_q && req_s) |=> own_q);
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter
    import arb_pkg::*;
#(
    parameter int N_MOD       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MOD-1:0] req_i,
    output logic [N_MOD-1:0] own_o,
    output logic             grant_o,
    output logic             busy_o,
    output logic             request_o
);
    localparam int CHAIN_LEN = N_MOD + 1;

    logic [CHAIN_LEN-1:0] chain;
    logic [N_MOD-1:0]     pend_vec;
    logic                 grant;

    cell_out_t cell_out [N_MOD];

    arb_grant i_grant (
        .clk       (clk),
        .rst       (rst),
        .req_line  (request_o),
        .busy_line (busy_o),
        .grant     (grant)
    );

    assign chain[0] = grant;

    generate
        for (genvar k = 0; k < N_MOD; k++) begin : g_cell
            arb_cell #(.SYNC_STAGES(SYNC_STAGES)) i_cell (
                .clk       (clk),
                .rst       (rst),
                .req_async (req_i[k]),
                .gin       (chain[k]),
                .busy_line (busy_o),
                .co        (cell_out[k])
            );
            assign chain[k+1]  = cell_out[k].gout;
            assign pend_vec[k] = cell_out[k].pend;
            assign own_o[k]    = cell_out[k].own;
        end
    endgenerate

    // wired-OR shared lines
    assign busy_o    = |own_o;
    assign request_o = |pend_vec;
    assign grant_o   = grant;

    // R7: at most one owner
    p_one_owner_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_o));

    // R5: grant at the end of the chain means nobody requests or owns
    p_tail_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        chain[CHAIN_LEN-1] |-> (!busy_o && !request_o));
endmodule

// File: tb/test_daisy_arbiter.sv
module test_daisy_arbiter;
    localparam int N  = 4;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] own_o;
    logic         grant_o, busy_o, request_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    daisy_arbiter #(.N_MOD(N), .SYNC_STAGES(SS)) i_daisy_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .own_o     (own_o),
        .grant_o   (grant_o),
        .busy_o    (busy_o),
        .request_o (request_o)
    );

    // behavioural reference: sync pipe, owner index, grant phase
    logic [N-1:0] m_pipe [SS];
    int m_owner = -1;
    int m_phase = 0;   // 0 idle, 1 first grant cycle, 2 second, 3 wait

    function automatic logic [N-1:0] owner_vec(input int o);
        logic [N-1:0] v = '0;
        if (o >= 0) v[o] = 1'b1;
        return v;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] rs, pend;
        int win, nxt_owner, nxt_phase;
        logic busy;
        if (rst) begin
            for (int i = 0; i < SS; i++) m_pipe[i] = '0;
            m_owner = -1;
            m_phase = 0;
        end else begin
            rs   = m_pipe[SS-1];
            pend = rs & ~owner_vec(m_owner);
            busy = (m_owner >= 0);
            win  = -1;
            if (m_phase == 1 && !busy)
                for (int i = N-1; i >= 0; i--) if (pend[i]) win = i;
            nxt_owner = m_owner;
            if (m_owner >= 0 && !rs[m_owner]) nxt_owner = -1;
            if (win >= 0) nxt_owner = win;
            case (m_phase)
                0: nxt_phase = (pend != 0 && !busy) ? 1 : 0;
                1: nxt_phase = 2;
                2: nxt_phase = busy ? 3 : 0;
                default: nxt_phase = busy ? 3 : 0;
            endcase
            m_owner = nxt_owner;
            m_phase = nxt_phase;
            for (int i = SS-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = req_i;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [N-1:0] pend;
        @(negedge clk);
        pend = m_pipe[SS-1] & ~owner_vec(m_owner);
        chk(int'(own_o), int'(owner_vec(m_owner)), "R4 R5 R6 R7 own");
        chk(int'(grant_o), int'(m_phase == 1 || m_phase == 2), "R3 R10 grant");
        chk(int'(busy_o), int'(m_owner >= 0), "R8 busy");
        chk(int'(request_o), int'(pend != 0), "R2 R9 request");
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        // R1 reset state
        chk(int'(own_o), 0, "R1 own");
        chk(int'(grant_o), 0, "R1 grant");
        chk(int'(busy_o), 0, "R1 busy");
        chk(int'(request_o), 0, "R1 request");

        // single request from cell 2: grant passes cells 0 and 1
        req_i = 4'b0100; run(8);
        chk(int'(own_o), 4, "R5 pass-through");
        chk(int'(busy_o), 1, "R8 busy held");
        chk(int'(request_o), 0, "R9 owner off request");

        // higher priority request while bus is busy
        req_i = 4'b0101; run(8);
        chk(int'(own_o), 4, "R7 no pre-emption");
        chk(int'(grant_o), 0, "R3 no grant while busy");
        chk(int'(request_o), 1, "R2 pending waiter");
        req_i = 4'b0001; run(10);
        chk(int'(own_o), 1, "R8 hand-over after release");
        req_i = 4'b0000; run(6);
        chk(int'(busy_o), 0, "R8 release");

        // simultaneous requests: lowest index wins
        req_i = 4'b1010; run(8);
        chk(int'(own_o), 2, "R6 priority");
        req_i = 4'b1000; run(10);
        chk(int'(own_o), 8, "R6 next in line");
        req_i = 4'b0000; run(6);

        // short pulse: grant rises, nobody captures, grant returns low
        req_i = 4'b0010; run(1);
        req_i = 4'b0000; run(8);
        chk(int'(grant_o), 0, "R10 grant re-armed");
        chk(int'(own_o), 0, "R10 no capture");

        // random traffic, including late upstream requests (R4 R10)
        for (int c = 0; c < 3000; c++) begin
            for (int b = 0; b < N; b++)
                if ($urandom_range(0, 11) == 0) req_i[b] = ~req_i[b];
            tick();
        end
        req_i = '0; run(10);
        chk(int'(busy_o), 0, "R8 final idle");

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule